// File: doc/BRIEF.md
# SPI Master Command-Frame Sequencer

This block runs a stream of 32-bit command frames as SPI master transfers. Software pushes frames into a four-entry queue. The sequencer takes them one at a time and asserts the chip-selects named in each frame. It shifts out the frame's data word while capturing MISO, then hands the received word back with a one-cycle valid strobe.

Each frame picks one of eight attribute sets, so clock polarity, clock phase, frame length and SCK rate can change from one frame to the next. A frame can leave its chip-selects asserted so that the next frame continues the same selection. A frame can also mark the end of a queue. When such a frame completes, a status flag is raised and the sequencer pauses until software clears that flag.

Top module: `spi_cmd_seq`

## Requirements
- R1: Command word fields are: bits [15:0] transmit data, bits [23:16] chip-select mask, bits [26:24] attribute-set code, bit 27 end-of-queue, bit 28 continuous. Bits [31:29] have no effect. Mask bit i drives `cs_no[i]`, and a low level means asserted.
- R2: Attribute code k uses `attr_cpol_i[k]`, `attr_cpha_i[k]`, `attr_size_i[4k+3:4k]` and `attr_div_i[8k+7:8k]`. The frame length is size+1 bits, with any value below 4 raised to 4. Each SCK half period lasts div+1 clock cycles.
- R3: A frame of N bits sends data bits N-1 down to 0, MSB first, over exactly N SCK pulses. SCK idles at CPOL. With CPHA=0, MISO is sampled on leading edges and MOSI changes on trailing edges. With CPHA=1 this is reversed.
- R4: For the whole transfer, `cs_no` equals the bitwise inverse of the frame's mask.
- R5: After a frame with continuous=0, all chip-selects go high in the cycle its valid strobe appears. They stay high for at least 2*(div+1) cycles of that frame's attribute set before the next frame's first SCK edge.
- R6: After a frame with continuous=1, its chip-selects stay asserted until the next frame begins. No cycle with all chip-selects high occurs in between.
- R7: `rx_valid_o` pulses for one cycle at the end of every frame. `rx_data_o` then holds the N received bits right-justified, with the upper bits zero.
- R8: A frame with end-of-queue=1 sets `eoq_flag_o` when it completes. No further frame starts until `eoq_clr_i` is pulsed, and that pulse clears the flag.
- R9: A frame with both end-of-queue and continuous set is run as continuous=0. It sets `cmd_err_o`, which stays set until reset.
- R10: The queue holds 4 frames and `full_o` is high while it holds 4. A push while full is dropped, and the dropped frame is never run.
- R11: During reset, `cs_no` is all ones. `sck_o`, `mosi_o`, `rx_valid_o`, `eoq_flag_o`, `cmd_err_o` and `full_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 32 | Command frame to queue |
| push_i | input | 1 | Push `cmd_i` into the queue |
| full_o | output | 1 | Queue holds 4 frames |
| attr_cpol_i | input | 8 | Clock polarity per attribute set |
| attr_cpha_i | input | 8 | Clock phase per attribute set |
| attr_size_i | input | 32 | Frame length minus one, 4 bits per set |
| attr_div_i | input | 64 | Half-period length minus one, 8 bits per set |
| eoq_clr_i | input | 1 | Clear end-of-queue flag and resume |
| miso_i | input | 1 | Serial data from the selected device |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the selected device |
| cs_no | output | 8 | Chip-selects, active low |
| rx_data_o | output | 16 | Last received word |
| rx_valid_o | output | 1 | One-cycle strobe, `rx_data_o` is new |
| eoq_flag_o | output | 1 | End-of-queue frame has completed |
| cmd_err_o | output | 1 | A frame carried end-of-queue and continuous together |

## Verification
The bench builds the block with its default parameters: a queue of four entries and 8-bit dividers. All eight attribute sets are loaded with different CPOL/CPHA pairs, frame lengths from 4 to 16 bits (including one length that must be clamped) and dividers of 0 to 2. With these settings every mode and length combination can be swept with several data patterns in a few thousand cycles. A bench-side slave answers each frame and measures every SCK half period. The four-deep queue lets the bench fill it behind a paused end-of-queue state and exercise the overflow drop directly.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned CS_W     = 8;
  localparam int unsigned SEL_W    = 3;
  localparam int unsigned N_ATTR   = 1 << SEL_W;
  localparam int unsigned SIZE_W   = $clog2(DATA_W);
  localparam int unsigned DIV_W    = 8;
  localparam int unsigned MIN_BITS = 4;
  localparam int unsigned CMD_W    = 32;
  localparam int unsigned RSVD_W   = CMD_W - 2 - SEL_W - CS_W - DATA_W;

  typedef struct packed {
    logic [RSVD_W-1:0] rsvd;
    logic              cont;
    logic              eoq;
    logic [SEL_W-1:0]  sel;
    logic [CS_W-1:0]   cs;
    logic [DATA_W-1:0] data;
  } cmd_t;

  typedef struct packed {
    logic              cpol;
    logic              cpha;
    logic [SIZE_W-1:0] size_m1;
    logic [DIV_W-1:0]  div;
  } attr_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_GAP} seq_st_e;
endpackage

// File: rtl/spi_cmd_fifo.sv
module spi_cmd_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic             full_o,
  input  logic             pop_i,
  output logic             empty_o,
  output logic [WIDTH-1:0] rdata_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_q, rd_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  a_r10_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  a_r10_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && !pop_i |=> full_o && $stable(rdata_o));
endmodule

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || tick_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  attr_t             attr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              miso_i,
  output logic              sck_o,
  output logic              mosi_o,
  output logic [DATA_W-1:0] rx_o,
  output logic              done_o
);
  localparam int unsigned EDGE_W = $clog2(2 * DATA_W);

  logic              busy_q, lead_q, cpol_q, cpha_q, sck_q, mosi_q, done_q;
  logic [DIV_W-1:0]  div_q;
  logic [EDGE_W-1:0] edge_q, last_q, last_c;
  logic [DATA_W-1:0] tx_q, rx_q, aligned;
  logic [SIZE_W:0]   n_bits, shamt;
  logic              tick, leading, sample;

  always_comb begin
    n_bits = {1'b0, attr_i.size_m1} + 1'b1;
    if (n_bits < (SIZE_W+1)'(MIN_BITS)) n_bits = (SIZE_W+1)'(MIN_BITS);
    shamt   = (SIZE_W+1)'(DATA_W) - n_bits;
    aligned = data_i << shamt;
    last_c  = EDGE_W'({n_bits, 1'b0} - 1'b1);
  end

  spi_half_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i, .rst_ni, .en_i(busy_q), .div_i(div_q), .tick_o(tick)
  );

  assign leading = ~edge_q[0];
  assign sample  = leading ^ cpha_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; lead_q <= 1'b0; cpol_q <= 1'b0; cpha_q <= 1'b0;
      sck_q  <= 1'b0; mosi_q <= 1'b0; done_q <= 1'b0; div_q  <= '0;
      edge_q <= '0;   last_q <= '0;   tx_q   <= '0;   rx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        lead_q <= 1'b1;
        edge_q <= '0;
        last_q <= last_c;
        cpol_q <= attr_i.cpol;
        cpha_q <= attr_i.cpha;
        div_q  <= attr_i.div;
        sck_q  <= attr_i.cpol;
        rx_q   <= '0;
        if (attr_i.cpha) begin
          mosi_q <= 1'b0;
          tx_q   <= aligned;
        end else begin
          mosi_q <= aligned[DATA_W-1];
          tx_q   <= aligned << 1;
        end
      end else if (busy_q && tick) begin
        if (lead_q) begin
          lead_q <= 1'b0;
        end else begin
          sck_q  <= ~sck_q;
          edge_q <= edge_q + 1'b1;
          if (sample) begin
            rx_q <= {rx_q[DATA_W-2:0], miso_i};
          end else begin
            mosi_q <= tx_q[DATA_W-1];
            tx_q   <= tx_q << 1;
          end
          if (edge_q == last_q) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign sck_o  = sck_q;
  assign mosi_o = mosi_q;
  assign rx_o   = rx_q;
  assign done_o = done_q;

  a_r3_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> sck_q == cpol_q);
  a_r3_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
  a_r3_sck_still_lead: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && lead_q |=> $stable(sck_q));
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_cmd_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [CMD_W-1:0]         cmd_i,
  input  logic                     push_i,
  output logic                     full_o,
  input  logic [N_ATTR-1:0]        attr_cpol_i,
  input  logic [N_ATTR-1:0]        attr_cpha_i,
  input  logic [N_ATTR*SIZE_W-1:0] attr_size_i,
  input  logic [N_ATTR*DIV_W-1:0]  attr_div_i,
  input  logic                     eoq_clr_i,
  input  logic                     miso_i,
  output logic                     sck_o,
  output logic                     mosi_o,
  output logic [CS_W-1:0]          cs_no,
  output logic [DATA_W-1:0]        rx_data_o,
  output logic                     rx_valid_o,
  output logic                     eoq_flag_o,
  output logic                     cmd_err_o
);
  attr_t             attr_tab [N_ATTR];
  cmd_t              head;
  attr_t             head_attr;
  logic              empty, pop, eng_done, gap_tick;
  logic [DATA_W-1:0] eng_rx;
  logic              unused_rsvd;

  seq_st_e           st_q;
  logic [CS_W-1:0]   cs_q;
  logic              cont_q, feoq_q, eoq_q, err_q, rxv_q, gap_half_q;
  logic [DIV_W-1:0]  gap_div_q;
  logic [DATA_W-1:0] rxd_q;

  for (genvar g = 0; g < N_ATTR; g++) begin : g_attr
    assign attr_tab[g] = {attr_cpol_i[g], attr_cpha_i[g],
                          attr_size_i[g*SIZE_W +: SIZE_W],
                          attr_div_i[g*DIV_W +: DIV_W]};
  end

  spi_cmd_fifo #(.WIDTH(CMD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni, .push_i, .wdata_i(cmd_i), .full_o,
    .pop_i(pop), .empty_o(empty), .rdata_o(head)
  );

  assign unused_rsvd = ^head.rsvd;
  assign head_attr   = attr_tab[head.sel];
  assign pop         = (st_q == ST_IDLE) && !empty && !eoq_q;

  spi_shift_engine u_eng (
    .clk_i, .rst_ni, .start_i(pop), .attr_i(head_attr), .data_i(head.data),
    .miso_i, .sck_o, .mosi_o, .rx_o(eng_rx), .done_o(eng_done)
  );

  spi_half_tick #(.DIV_W(DIV_W)) u_gap (
    .clk_i, .rst_ni, .en_i(st_q == ST_GAP), .div_i(gap_div_q), .tick_o(gap_tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; cs_q <= '0; cont_q <= 1'b0; feoq_q <= 1'b0;
      eoq_q <= 1'b0; err_q <= 1'b0; rxv_q <= 1'b0; gap_half_q <= 1'b0;
      gap_div_q <= '0; rxd_q <= '0;
    end else begin
      rxv_q <= 1'b0;
      if (eoq_clr_i) eoq_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (pop) begin
          cs_q      <= head.cs;
          cont_q    <= head.cont && !head.eoq;  // illegal pair runs as a closing frame
          feoq_q    <= head.eoq;
          gap_div_q <= head_attr.div;
          if (head.cont && head.eoq) err_q <= 1'b1;
          st_q      <= ST_RUN;
        end
        ST_RUN: if (eng_done) begin
          rxd_q <= eng_rx;
          rxv_q <= 1'b1;
          if (feoq_q) eoq_q <= 1'b1;
          if (cont_q) begin
            st_q <= ST_IDLE;
          end else begin
            cs_q <= '0;
            st_q <= ST_GAP;
          end
        end
        ST_GAP: if (gap_tick) begin
          gap_half_q <= ~gap_half_q;
          if (gap_half_q) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_no      = ~cs_q;
  assign rx_data_o  = rxd_q;
  assign rx_valid_o = rxv_q;
  assign eoq_flag_o = eoq_q;
  assign cmd_err_o  = err_q;

  a_r4_cs_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_RUN && !eng_done |=> cs_q == $past(cs_q));
  a_r5_gap_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_GAP |-> cs_q == '0);
  a_r7_one_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
  a_r8_flag_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoq_flag_o && !eoq_clr_i |=> eoq_flag_o);
  a_r8_paused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoq_flag_o && st_q == ST_IDLE |=> st_q == ST_IDLE);
  a_r9_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_err_o |=> cmd_err_o);
endmodule

// File: tb/spi_cmd_seq_test.sv
module spi_cmd_seq_test;
  import spi_cmd_pkg::*;

  localparam int NF = 37;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                     rst_n;
  logic [CMD_W-1:0]         cmd;
  logic                     push, full, eoq_clr, miso;
  logic [N_ATTR-1:0]        a_cpol, a_cpha;
  logic [N_ATTR*SIZE_W-1:0] a_size;
  logic [N_ATTR*DIV_W-1:0]  a_div;
  logic                     sck, mosi, rx_valid, eoq_flag, cmd_err;
  logic [CS_W-1:0]          cs_n;
  logic [DATA_W-1:0]        rx_data;

  spi_cmd_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .push_i(push), .full_o(full),
    .attr_cpol_i(a_cpol), .attr_cpha_i(a_cpha), .attr_size_i(a_size),
    .attr_div_i(a_div), .eoq_clr_i(eoq_clr), .miso_i(miso), .sck_o(sck),
    .mosi_o(mosi), .cs_no(cs_n), .rx_data_o(rx_data), .rx_valid_o(rx_valid),
    .eoq_flag_o(eoq_flag), .cmd_err_o(cmd_err)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int f_size(input int k);
    case (k)
      0: return 7;  1: return 15; 2: return 3; 3: return 11;
      4: return 4;  5: return 9;  6: return 15; default: return 1;
    endcase
  endfunction
  function automatic int f_n(input int k);
    return (f_size(k) + 1 < 4) ? 4 : f_size(k) + 1;
  endfunction
  function automatic int f_div(input int k);
    return k % 3;
  endfunction

  function automatic logic [31:0] mk_cmd(input bit c, input bit e, input int sel,
                                         input logic [7:0] m, input logic [15:0] d);
    return {3'b101, c, e, 3'(sel), m, d};
  endfunction

  logic [31:0] fl_cmd  [NF+1];
  logic [15:0] fl_miso [NF+1];

  // bench-side slave and monitor state
  int fi = 0, edges = 0, frames_done = 0, gap_cnt = 0, cyc = 0, last_edge = 0;
  int prev_div = 0;
  bit prev_cont = 1'b0, sp_ok = 1'b1, cs_ok = 1'b1, prev_rxv = 1'b0;
  logic prev_sck = 1'b0;
  logic [15:0] slv_rx = '0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      int k, n, hp, idx;
      bit cp, ph, ce;
      logic [15:0] msk;
      k  = int'(fl_cmd[fi][26:24]);
      n  = f_n(k);
      cp = a_cpol[k];
      ph = a_cpha[k];
      hp = f_div(k) + 1;
      if (sck !== prev_sck) begin
        if (sck != cp) begin  // leading edge
          if (edges == 0) begin
            if (frames_done > 0) begin
              if (prev_cont) chk(gap_cnt == 0, "R6 no release inside continuous run", gap_cnt, 0);
              else chk(gap_cnt >= 2 * (prev_div + 1), "R5 idle time between frames",
                       gap_cnt, 2 * (prev_div + 1));
            end
          end else if (cyc - last_edge != hp) sp_ok = 1'b0;
          if (!ph) slv_rx = {slv_rx[14:0], mosi};
          else miso = fl_miso[fi][n - 1 - edges / 2];
          edges++;
          if (cs_n !== ~fl_cmd[fi][23:16]) cs_ok = 1'b0;
          last_edge = cyc;
        end else if (edges % 2 == 1) begin  // trailing edge
          if (cyc - last_edge != hp) sp_ok = 1'b0;
          edges++;
          if (ph) slv_rx = {slv_rx[14:0], mosi};
          else begin
            idx = edges / 2;
            if (idx < n) miso = fl_miso[fi][n - 1 - idx];
          end
          if (cs_n !== ~fl_cmd[fi][23:16]) cs_ok = 1'b0;
          last_edge = cyc;
        end
      end
      prev_sck = sck;
      if (&cs_n) gap_cnt++;
      if (rx_valid) begin
        msk = 16'((32'd1 << n) - 1);
        ce  = fl_cmd[fi][28] && !fl_cmd[fi][27];
        chk(rx_data == (fl_miso[fi] & msk), "R7 received word right-justified",
            int'(rx_data), int'(fl_miso[fi] & msk));
        chk(slv_rx == (fl_cmd[fi][15:0] & msk), "R3 MSB-first transmit, R1 data field",
            int'(slv_rx), int'(fl_cmd[fi][15:0] & msk));
        chk(edges == 2 * n, "R3 SCK edge count / R2 frame size", edges, 2 * n);
        chk(sck == cp, "R3 SCK idle level", int'(sck), int'(cp));
        chk(cs_ok, "R4 chip-select mask during transfer", int'(cs_n), int'(~fl_cmd[fi][23:16]));
        chk(sp_ok, "R2 half period length", 0, hp);
        chk(!prev_rxv, "R7 single-cycle strobe", int'(prev_rxv), 0);
        if (ce) chk(cs_n == ~fl_cmd[fi][23:16], "R6 select held after continuous frame",
                    int'(cs_n), int'(~fl_cmd[fi][23:16]));
        else if (fl_cmd[fi][28]) chk(&cs_n, "R9 illegal pair releases selects", int'(cs_n), 8'hff);
        else chk(&cs_n, "R5 selects released after frame", int'(cs_n), 8'hff);
        prev_cont = ce;
        prev_div  = f_div(k);
        frames_done++;
        if (fi < NF) fi++;
        edges = 0; slv_rx = '0; gap_cnt = 0; sp_ok = 1'b1; cs_ok = 1'b1;
        k = int'(fl_cmd[fi][26:24]);
        if (!a_cpha[k]) miso = fl_miso[fi][f_n(k) - 1];
      end
      prev_rxv = rx_valid;
    end
  end

  task automatic push_cmd(input logic [31:0] c);
    while (full) @(negedge clk);
    cmd = c; push = 1'b1;
    @(negedge clk);
    push = 1'b0;
  endtask

  task automatic push_raw(input logic [31:0] c);
    cmd = c; push = 1'b1;
    @(negedge clk);
    push = 1'b0;
  endtask

  task automatic pulse_clr();
    eoq_clr = 1'b1;
    @(negedge clk);
    eoq_clr = 1'b0;
  endtask

  task automatic wait_frames(input int n);
    int t = 0;
    while (frames_done < n && t < 20000) begin
      @(negedge clk);
      t++;
    end
    chk(frames_done >= n, "R10 frames completed before timeout", frames_done, n);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", frames_done, NF);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; push = 1'b0; eoq_clr = 1'b0; cmd = '0; miso = 1'b0;
    for (int k = 0; k < N_ATTR; k++) begin
      a_cpol[k] = k[0];
      a_cpha[k] = k[1];
      a_size[k*SIZE_W +: SIZE_W] = SIZE_W'(f_size(k));
      a_div[k*DIV_W +: DIV_W]    = DIV_W'(f_div(k));
    end
    for (int i = 0; i < 32; i++) begin
      int s, p;
      logic [15:0] d;
      logic [7:0]  m;
      s = i / 4; p = i % 4;
      d = 16'hA5C3 ^ 16'(s * 16'h1357) ^ 16'(p * 16'h2468);
      m = 8'(1 << ((s + p) % 8)) | ((p == 3) ? 8'hF0 : 8'h00);
      fl_cmd[i] = mk_cmd(p == 1, 1'b0, s, m, d);
    end
    fl_cmd[32] = mk_cmd(1'b0, 1'b1, 5, 8'h81, 16'h3CA5);
    fl_cmd[33] = mk_cmd(1'b1, 1'b0, 0, 8'h02, 16'h00FF);
    fl_cmd[34] = mk_cmd(1'b0, 1'b0, 1, 8'h04, 16'hF00F);
    fl_cmd[35] = mk_cmd(1'b0, 1'b0, 7, 8'h40, 16'hFFF9);
    fl_cmd[36] = mk_cmd(1'b1, 1'b1, 6, 8'h18, 16'h5AA5);
    fl_cmd[37] = mk_cmd(1'b0, 1'b0, 0, 8'h01, 16'h0000);
    for (int i = 0; i <= NF; i++)
      fl_miso[i] = {fl_cmd[i][7:0], fl_cmd[i][15:8]} ^ 16'h0F0F;
    miso = fl_miso[0][f_n(0) - 1];

    repeat (4) @(negedge clk);
    chk(cs_n == 8'hFF, "R11 reset chip-selects", int'(cs_n), 8'hFF);
    chk(!sck && !mosi, "R11 reset SCK/MOSI", int'({sck, mosi}), 0);
    chk(!rx_valid && !eoq_flag && !cmd_err && !full, "R11 reset flags",
        int'({rx_valid, eoq_flag, cmd_err, full}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 32; i++) push_cmd(fl_cmd[i]);
    wait_frames(32);

    push_cmd(fl_cmd[32]);
    wait_frames(33);
    @(negedge clk);
    chk(eoq_flag, "R8 flag set after end-of-queue frame", int'(eoq_flag), 1);
    for (int i = 33; i <= 36; i++) push_cmd(fl_cmd[i]);
    chk(full, "R10 full with four queued", int'(full), 1);
    push_raw(mk_cmd(1'b0, 1'b0, 2, 8'hFF, 16'hDEAD));  // dropped
    repeat (100) @(negedge clk);
    chk(frames_done == 33, "R8 no frame while flag set", frames_done, 33);
    chk(cs_n == 8'hFF, "R8 selects idle while paused", int'(cs_n), 8'hFF);
    chk(eoq_flag, "R8 flag holds until cleared", int'(eoq_flag), 1);
    chk(!cmd_err, "R9 no error before illegal frame", int'(cmd_err), 0);
    pulse_clr();
    chk(!eoq_flag, "R8 flag cleared by pulse", int'(eoq_flag), 0);
    wait_frames(37);
    @(negedge clk);
    chk(cmd_err, "R9 error on end-of-queue with continuous", int'(cmd_err), 1);
    chk(eoq_flag, "R8 flag set by illegal-pair frame", int'(eoq_flag), 1);
    pulse_clr();
    repeat (200) @(negedge clk);
    chk(cmd_err, "R9 error sticky", int'(cmd_err), 1);
    chk(frames_done == NF, "R10 dropped push never runs", frames_done, NF);
    chk(!full, "R10 queue drained", int'(full), 0);
    finish_run();
  end
endmodule